// File: doc/BRIEF.md
# Near Return Sequencer with Shadow Check

This block carries out a near procedure return, one instruction at a time. A start pulse brings in the operand size, the stack-address size, an optional 16-bit byte count to release, the stack pointer, the shadow-stack pointer and two limits. The sequencer first checks that the bytes it is about to pop lie under the stack limit. It then reads the return pointer through a data-memory read port and masks it to the operand width. A 16-bit pointer is also checked against the code limit. When shadow checking is on, the sequencer reads a second copy through a separate shadow port and compares it with the popped pointer. Last, it applies the byte release to the stack pointer.

On success the new instruction pointer, stack pointer and (when shadow checking is on) shadow pointer are committed together with a one-cycle done strobe. On any fault nothing is committed. A one-cycle fault strobe carries a class code and an error code instead. The code-segment selector is not part of this block: a near return never touches it.

Both read ports use the same request/valid rule. The request rises with its address and size and stays high with all three held steady until the cycle in which read-valid is high. The read data is taken in that cycle. A slow memory applies back-pressure simply by holding read-valid low. Read-valid is ignored while no request is pending. The control pins (start, busy, done, fault) are plain levels and pulses.

Top module: `nret_seq`

## Requirements
- R1: A pop raises the data request with address equal to the stack pointer masked to the stack-address width (size code 0 = 16 bits, 1 = 32, 2 or 3 = 64). The size output gives the resolved operand code (0 = 2 bytes, 1 = 4, 2 = 8). Request, address and size hold until read-valid, and the request drops the cycle after.
- R2: If the last byte of the pop (masked address + bytes − 1, computed without wrap) exceeds the stack limit, the block signals fault class 1 with error 0 and issues no pop. A pop whose last byte equals the limit proceeds.
- R3: The popped pointer is masked to the operand width (16 or 32 bits, or kept whole for 64). For a 16-bit operand, a masked pointer above the code limit gives fault class 2 with error 0. A pointer equal to the limit is accepted.
- R4: With shadow checking on, a 4-byte shadow pop (wide flag low) is done for 16- and 32-bit returns and an 8-byte one for 64-bit returns. It reads at the shadow pointer, and the pointer advances by 4 or 8 on success. For a 4-byte pop, only the low 32 bits of the read data are compared, zero-extended. A mismatch gives fault class 3 with error code 0x0001.
- R5: When the immediate flag is set, the immediate is added to the stack pointer after the pop increment, at the stack-address width.
- R6: Stack-pointer updates wrap modulo the stack-address width and leave the bits above that width unchanged.
- R7: Operand code 3 selects the default size: 64 bits when the long-mode input is high, else 32 bits.
- R8: On a fault, the instruction, stack and shadow pointer outputs keep their previous values. The fault strobe lasts one cycle.
- R9: Done lasts one cycle. Busy is high from the cycle after start until the strobe. A start pulse while busy is ignored.
- R10: After reset, all pointer outputs, strobes, busy and both requests are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a return (sampled when idle) |
| opsz_i | input | 2 | Operand size code: 0=16, 1=32, 2=64, 3=default |
| asz_i | input | 2 | Stack-address size code: 0=16, 1=32, 2/3=64 |
| long_mode_i | input | 1 | Selects 64-bit default operand size |
| imm_en_i | input | 1 | Immediate byte release present |
| imm_i | input | 16 | Bytes to release |
| shadow_en_i | input | 1 | Enable shadow-copy check |
| sp_i | input | 64 | Stack pointer at start |
| ssp_i | input | 64 | Shadow-stack pointer at start |
| stk_lim_i | input | 64 | Highest valid stack byte address |
| cs_lim_i | input | 64 | Highest valid code offset |
| dmem_req_o | output | 1 | Data-stack read request |
| dmem_addr_o | output | 64 | Data-stack read address |
| dmem_size_o | output | 2 | Data-stack read size code |
| dmem_rvalid_i | input | 1 | Data-stack read data valid |
| dmem_rdata_i | input | 64 | Data-stack read data |
| ss_req_o | output | 1 | Shadow read request |
| ss_addr_o | output | 64 | Shadow read address |
| ss_wide_o | output | 1 | Shadow read is 8 bytes (else 4) |
| ss_rvalid_i | input | 1 | Shadow read data valid |
| ss_rdata_i | input | 64 | Shadow read data |
| busy_o | output | 1 | Return in progress |
| done_o | output | 1 | One-cycle success strobe |
| fault_o | output | 1 | One-cycle fault strobe |
| fault_cls_o | output | 3 | Fault class: 1 stack, 2 protection, 3 control |
| fault_err_o | output | 16 | Fault error code |
| ip_o | output | 64 | Committed instruction pointer |
| sp_o | output | 64 | Committed stack pointer |
| ssp_o | output | 64 | Committed shadow pointer |

## Verification
The hardest case to reach is a shadow mismatch that has to win over a pending byte release. The data pop must succeed and pass the code limit, and only the second read may disagree. The stimulus reaches it with a 64-bit return where the data and shadow responders return values that differ only above bit 31. A separate 32-bit case returns shadow data that differs from the data pop only in its upper half, and this must be accepted. Back-pressure is reached by giving the data responder a multi-cycle latency while a second start pulse arrives mid-wait.

// File: rtl/nret_pkg.sv
package nret_pkg;
  typedef enum logic [1:0] {SZ16 = 2'd0, SZ32 = 2'd1, SZ64 = 2'd2, SZDEF = 2'd3} size_e;
  typedef enum logic [2:0] {FC_NONE = 3'd0, FC_STACK = 3'd1, FC_GP = 3'd2, FC_CP = 3'd3} fclass_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_DPOP, ST_SPOP} state_e;
  localparam logic [15:0] ERR_NEAR_RET = 16'h0001;
  localparam logic [15:0] ERR_ZERO     = 16'h0000;
endpackage

// File: rtl/nret_port.sv
module nret_port #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [XLEN-1:0] addr_i,
  output logic            req_o,
  output logic [XLEN-1:0] addr_o,
  input  logic            rvalid_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic            done_o,
  output logic [XLEN-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      addr_o <= '0;
    end else if (issue_i) begin
      req_o  <= 1'b1;
      addr_o <= addr_i;
    end else if (req_o && rvalid_i) begin
      req_o  <= 1'b0;
    end
  end

  assign done_o = req_o && rvalid_i;
  assign data_o = rdata_i;

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !rvalid_i) |=> (req_o && $stable(addr_o)));
  assert_req_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && rvalid_i) |=> !req_o);
endmodule

// File: rtl/nret_limit.sv
module nret_limit #(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  logic [1:0]      opsz_i,
  input  logic [1:0]      asz_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] lim_i,
  input  logic [XLEN-1:0] raw_ip_i,
  input  logic [XLEN-1:0] cs_lim_i,
  input  logic            imm_en_i,
  input  logic [IMMW-1:0] imm_i,
  output logic            stk_fault_o,
  output logic [XLEN-1:0] pop_addr_o,
  output logic [XLEN-1:0] ip_clean_o,
  output logic            cs_fault_o,
  output logic [XLEN-1:0] sp_final_o
);
  import nret_pkg::*;

  function automatic logic [XLEN-1:0] width_mask(input logic [1:0] c);
    case (c)
      SZ16:    return XLEN'(16'hFFFF);
      SZ32:    return XLEN'(32'hFFFF_FFFF);
      default: return '1;
    endcase
  endfunction

  logic [XLEN-1:0] amask, omask, sp_popped, inc;
  logic [3:0]      nbytes;
  logic [XLEN:0]   last_byte;

  always_comb begin
    amask      = width_mask(asz_i);
    omask      = width_mask(opsz_i);
    case (opsz_i)
      SZ16:    nbytes = 4'd2;
      SZ32:    nbytes = 4'd4;
      default: nbytes = 4'd8;
    endcase
    pop_addr_o  = sp_i & amask;
    last_byte   = {1'b0, pop_addr_o} + (XLEN+1)'(nbytes) - (XLEN+1)'(1);
    stk_fault_o = last_byte > {1'b0, lim_i};
    sp_popped   = (sp_i & ~amask) | ((sp_i + XLEN'(nbytes)) & amask);
    inc         = imm_en_i ? XLEN'(imm_i) : '0;
    sp_final_o  = (sp_popped & ~amask) | ((sp_popped + inc) & amask);
    ip_clean_o  = raw_ip_i & omask;
    cs_fault_o  = (opsz_i == SZ16) && (ip_clean_o > cs_lim_i);
  end

  always_comb begin
    if (!stk_fault_o) assert_fit_R2: assert ({1'b0, pop_addr_o} <= {1'b0, lim_i});
  end
endmodule

// File: rtl/nret_seq.sv
module nret_seq
  import nret_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16,
  parameter int ERRW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      opsz_i,
  input  logic [1:0]      asz_i,
  input  logic            long_mode_i,
  input  logic            imm_en_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            shadow_en_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] ssp_i,
  input  logic [XLEN-1:0] stk_lim_i,
  input  logic [XLEN-1:0] cs_lim_i,
  output logic            dmem_req_o,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [1:0]      dmem_size_o,
  input  logic            dmem_rvalid_i,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic            ss_req_o,
  output logic [XLEN-1:0] ss_addr_o,
  output logic            ss_wide_o,
  input  logic            ss_rvalid_i,
  input  logic [XLEN-1:0] ss_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fault_o,
  output logic [2:0]      fault_cls_o,
  output logic [ERRW-1:0] fault_err_o,
  output logic [XLEN-1:0] ip_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] ssp_o
);
  localparam int SS_NARROW = 4;
  localparam int SS_WIDE   = 8;

  state_e          st_q;
  logic [1:0]      opsz_q, asz_q;
  logic            imm_en_q, shen_q;
  logic [IMMW-1:0] imm_q;
  logic [XLEN-1:0] sp_in_q, ssp_in_q, lim_q, cslim_q, ip_tmp_q;
  logic [1:0]      opsz_res;

  logic            stk_fault, cs_fault, d_issue, d_done, s_issue, s_done, ss_bad;
  logic [XLEN-1:0] pop_addr, ip_clean, sp_final, d_data, s_data, ss_val, ssp_next;

  assign opsz_res = (opsz_i == SZDEF) ? (long_mode_i ? SZ64 : SZ32) : opsz_i;

  nret_limit #(.XLEN(XLEN), .IMMW(IMMW)) u_limit (
    .opsz_i(opsz_q), .asz_i(asz_q), .sp_i(sp_in_q), .lim_i(lim_q),
    .raw_ip_i(d_data), .cs_lim_i(cslim_q), .imm_en_i(imm_en_q), .imm_i(imm_q),
    .stk_fault_o(stk_fault), .pop_addr_o(pop_addr), .ip_clean_o(ip_clean),
    .cs_fault_o(cs_fault), .sp_final_o(sp_final)
  );

  assign d_issue = (st_q == ST_CHECK) && !stk_fault;
  assign s_issue = (st_q == ST_DPOP) && d_done && !cs_fault && shen_q;

  nret_port #(.XLEN(XLEN)) u_dport (
    .clk(clk), .rst_n(rst_n), .issue_i(d_issue), .addr_i(pop_addr),
    .req_o(dmem_req_o), .addr_o(dmem_addr_o), .rvalid_i(dmem_rvalid_i),
    .rdata_i(dmem_rdata_i), .done_o(d_done), .data_o(d_data)
  );

  nret_port #(.XLEN(XLEN)) u_sport (
    .clk(clk), .rst_n(rst_n), .issue_i(s_issue), .addr_i(ssp_in_q),
    .req_o(ss_req_o), .addr_o(ss_addr_o), .rvalid_i(ss_rvalid_i),
    .rdata_i(ss_rdata_i), .done_o(s_done), .data_o(s_data)
  );

  assign dmem_size_o = opsz_q;
  assign ss_wide_o   = (opsz_q == SZ64);
  assign ss_val      = ss_wide_o ? s_data : XLEN'(s_data[31:0]);
  assign ss_bad      = ss_val != ip_tmp_q;
  assign ssp_next    = ssp_in_q + (ss_wide_o ? XLEN'(SS_WIDE) : XLEN'(SS_NARROW));
  assign busy_o      = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      opsz_q <= '0; asz_q <= '0; imm_en_q <= 1'b0; shen_q <= 1'b0; imm_q <= '0;
      sp_in_q <= '0; ssp_in_q <= '0; lim_q <= '0; cslim_q <= '0; ip_tmp_q <= '0;
      ip_o <= '0; sp_o <= '0; ssp_o <= '0;
      done_o <= 1'b0; fault_o <= 1'b0; fault_cls_o <= FC_NONE; fault_err_o <= '0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          opsz_q   <= opsz_res;
          asz_q    <= asz_i;
          imm_en_q <= imm_en_i;
          imm_q    <= imm_i;
          shen_q   <= shadow_en_i;
          sp_in_q  <= sp_i;
          ssp_in_q <= ssp_i;
          lim_q    <= stk_lim_i;
          cslim_q  <= cs_lim_i;
          st_q     <= ST_CHECK;
        end
        ST_CHECK: if (stk_fault) begin
          fault_o     <= 1'b1;
          fault_cls_o <= FC_STACK;
          fault_err_o <= ERR_ZERO;
          st_q        <= ST_IDLE;
        end else begin
          st_q <= ST_DPOP;
        end
        ST_DPOP: if (d_done) begin
          if (cs_fault) begin
            fault_o     <= 1'b1;
            fault_cls_o <= FC_GP;
            fault_err_o <= ERR_ZERO;
            st_q        <= ST_IDLE;
          end else if (shen_q) begin
            ip_tmp_q <= ip_clean;
            st_q     <= ST_SPOP;
          end else begin
            ip_o   <= ip_clean;
            sp_o   <= sp_final;
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_SPOP: if (s_done) begin
          if (ss_bad) begin
            fault_o     <= 1'b1;
            fault_cls_o <= FC_CP;
            fault_err_o <= ERR_NEAR_RET;
          end else begin
            ip_o   <= ip_tmp_q;
            sp_o   <= sp_final;
            ssp_o  <= ssp_next;
            done_o <= 1'b1;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_no_pop_on_stkfault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && fault_cls_o == FC_STACK) |-> !$past(dmem_req_o));
  assert_cp_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && fault_cls_o == FC_CP) |-> (fault_err_o == ERR_NEAR_RET));
  assert_shadow_after_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req_o |-> !dmem_req_o);
  assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o);
  assert_commit_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ip_o) || !$stable(sp_o) || !$stable(ssp_o)) |-> done_o);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));
endmodule

// File: tb/nret_seq_bench.sv
`timescale 1ns/1ps
module nret_seq_bench;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [1:0]  opsz;
    logic [1:0]  asz;
    logic        m64;
    logic        imm_en;
    logic [15:0] imm;
    logic        shen;
    logic [63:0] sp;
    logic [63:0] ssp;
    logic [63:0] lim;
    logic [63:0] cslim;
    logic [63:0] dd;
    logic [63:0] sd;
    logic [2:0]  ecls;
    logic [63:0] eip;
    logic [63:0] esp;
    logic [63:0] essp;
    logic [63:0] edaddr;
    logic [1:0]  edpops;
    logic [1:0]  espops;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd1,2'd1,1'b0,1'b0,16'h0,1'b0,64'h1000,64'h0,ONES,ONES,64'hDEAD_BEEF_1234_5678,64'h0,3'd0,64'h1234_5678,64'h1004,64'h0,64'h1000,2'd1,2'd0},
    '{2'd2,2'd2,1'b0,1'b1,16'h10,1'b0,64'h8000,64'h0,ONES,ONES,64'h0000_7FFF_0000_4000,64'h0,3'd0,64'h0000_7FFF_0000_4000,64'h8018,64'h0,64'h8000,2'd1,2'd0},
    '{2'd0,2'd0,1'b0,1'b0,16'h0,1'b0,64'hABCD_0000_0000_FFF0,64'h0,64'hFFFF,64'hFFFF,64'h1111_2222_3333_4444,64'h0,3'd0,64'h4444,64'hABCD_0000_0000_FFF2,64'h0,64'hFFF0,2'd1,2'd0},
    '{2'd0,2'd0,1'b0,1'b1,16'h4,1'b0,64'h1_FFFE,64'h0,64'hFFFF,64'hFFFF,64'h2000,64'h0,3'd0,64'h2000,64'h1_0004,64'h0,64'hFFFE,2'd1,2'd0},
    '{2'd1,2'd1,1'b0,1'b0,16'h0,1'b0,64'h0FFE,64'h0,64'h0FFF,ONES,64'h99,64'h0,3'd1,64'h0,64'h0,64'h0,64'h0,2'd0,2'd0},
    '{2'd1,2'd1,1'b0,1'b0,16'h0,1'b0,64'h0FFC,64'h0,64'h0FFF,ONES,64'h55,64'h0,3'd0,64'h55,64'h1000,64'h0,64'h0FFC,2'd1,2'd0},
    '{2'd0,2'd1,1'b0,1'b0,16'h0,1'b0,64'h2000,64'h0,ONES,64'h0FFF,64'hFFFF_0000_0000_1000,64'h0,3'd2,64'h0,64'h0,64'h0,64'h2000,2'd1,2'd0},
    '{2'd1,2'd1,1'b0,1'b0,16'h0,1'b1,64'h3000,64'h9000,ONES,ONES,64'hCAFE_0000,64'hFFFF_FFFF_CAFE_0000,3'd0,64'hCAFE_0000,64'h3004,64'h9004,64'h3000,2'd1,2'd1},
    '{2'd2,2'd2,1'b0,1'b1,16'h8,1'b1,64'h4000,64'hA000,ONES,ONES,64'h1_0000_0000,64'h2_0000_0000,3'd3,64'h0,64'h0,64'h0,64'h4000,2'd1,2'd1},
    '{2'd3,2'd2,1'b1,1'b0,16'h0,1'b1,64'h5000,64'hB000,ONES,ONES,64'h8765_4321_0000_0042,64'h8765_4321_0000_0042,3'd0,64'h8765_4321_0000_0042,64'h5008,64'hB008,64'h5000,2'd1,2'd1},
    '{2'd3,2'd1,1'b0,1'b0,16'h0,1'b0,64'h6000,64'h0,ONES,ONES,64'h8765_4321_0000_0042,64'h0,3'd0,64'h42,64'h6004,64'hB008,64'h6000,2'd1,2'd0},
    '{2'd1,2'd1,1'b0,1'b1,16'h8,1'b0,64'h1_FFFF_FFF8,64'h0,ONES,ONES,64'h77,64'h0,3'd0,64'h77,64'h1_0000_0004,64'hB008,64'hFFFF_FFF8,2'd1,2'd0},
    '{2'd0,2'd1,1'b0,1'b0,16'h0,1'b1,64'h7000,64'hC000,ONES,64'h0FFF,64'hFFFF_FFFF_FFFF_0FFF,64'h0FFF,3'd0,64'h0FFF,64'h7002,64'hC004,64'h7000,2'd1,2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, long_mode_i = 1'b0, imm_en_i = 1'b0, shadow_en_i = 1'b0;
  logic [1:0] opsz_i = '0, asz_i = '0;
  logic [15:0] imm_i = '0;
  logic [63:0] sp_i = '0, ssp_i = '0, stk_lim_i = '0, cs_lim_i = '0;
  logic dmem_req_o, ss_req_o, ss_wide_o, busy_o, done_o, fault_o;
  logic dmem_rvalid_i = 1'b0, ss_rvalid_i = 1'b0;
  logic [63:0] dmem_rdata_i = '0, ss_rdata_i = '0;
  logic [63:0] dmem_addr_o, ss_addr_o, ip_o, sp_o, ssp_o;
  logic [1:0] dmem_size_o;
  logic [2:0] fault_cls_o;
  logic [15:0] fault_err_o;

  logic [63:0] cur_dd = '0, cur_sd = '0;
  int d_lat = 0, s_lat = 1;
  int d_wait = 0, s_wait = 0, d_pops = 0, s_pops = 0;
  logic [63:0] d_addr = '0, s_addr = '0;
  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nret_seq u_nret_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opsz_i(opsz_i), .asz_i(asz_i),
    .long_mode_i(long_mode_i), .imm_en_i(imm_en_i), .imm_i(imm_i),
    .shadow_en_i(shadow_en_i), .sp_i(sp_i), .ssp_i(ssp_i), .stk_lim_i(stk_lim_i),
    .cs_lim_i(cs_lim_i), .dmem_req_o(dmem_req_o), .dmem_addr_o(dmem_addr_o),
    .dmem_size_o(dmem_size_o), .dmem_rvalid_i(dmem_rvalid_i), .dmem_rdata_i(dmem_rdata_i),
    .ss_req_o(ss_req_o), .ss_addr_o(ss_addr_o), .ss_wide_o(ss_wide_o),
    .ss_rvalid_i(ss_rvalid_i), .ss_rdata_i(ss_rdata_i), .busy_o(busy_o),
    .done_o(done_o), .fault_o(fault_o), .fault_cls_o(fault_cls_o),
    .fault_err_o(fault_err_o), .ip_o(ip_o), .sp_o(sp_o), .ssp_o(ssp_o)
  );

  // memory responders, driven away from the active edge
  always @(negedge clk) begin
    if (dmem_rvalid_i) dmem_rvalid_i <= 1'b0;
    else if (dmem_req_o) begin
      if (d_wait >= d_lat) begin
        dmem_rvalid_i <= 1'b1; dmem_rdata_i <= cur_dd;
        d_addr <= dmem_addr_o; d_pops <= d_pops + 1; d_wait <= 0;
      end else d_wait <= d_wait + 1;
    end
    if (ss_rvalid_i) ss_rvalid_i <= 1'b0;
    else if (ss_req_o) begin
      if (s_wait >= s_lat) begin
        ss_rvalid_i <= 1'b1; ss_rdata_i <= cur_sd;
        s_addr <= ss_addr_o; s_pops <= s_pops + 1; s_wait <= 0;
      end else s_wait <= s_wait + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    opsz_i = v.opsz; asz_i = v.asz; long_mode_i = v.m64; imm_en_i = v.imm_en;
    imm_i = v.imm; shadow_en_i = v.shen; sp_i = v.sp; ssp_i = v.ssp;
    stk_lim_i = v.lim; cs_lim_i = v.cslim; cur_dd = v.dd; cur_sd = v.sd;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 60; k++) begin
      if (done_o || fault_o) break;
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [63:0] pip, psp, pssp;
    int d0, s0;
    pip = ip_o; psp = sp_o; pssp = ssp_o; d0 = d_pops; s0 = s_pops;
    launch(v);
    wait_end();
    chk("R2 R3 R4", "fault class", 64'(fault_o ? fault_cls_o : 3'd0), 64'(v.ecls));
    chk("R9", "done strobe", 64'(done_o), 64'(v.ecls == 3'd0));
    if (v.ecls != 3'd0) begin
      chk("R4", "error code", 64'(fault_err_o), (v.ecls == 3'd3) ? 64'h1 : 64'h0);
      chk("R8", "ip kept", ip_o, pip);
      chk("R8", "sp kept", sp_o, psp);
      chk("R8", "ssp kept", ssp_o, pssp);
    end else begin
      chk("R3 R7", "ip", ip_o, v.eip);
      chk("R5 R6", "sp", sp_o, v.esp);
      chk("R4", "ssp", ssp_o, v.essp);
    end
    chk("R1 R2", "data pops", 64'(d_pops - d0), 64'(v.edpops));
    chk("R4", "shadow pops", 64'(s_pops - s0), 64'(v.espops));
    if (v.edpops != 2'd0) chk("R1", "pop address", d_addr, v.edaddr);
    if (v.espops != 2'd0) chk("R4", "shadow address", s_addr, v.ssp);
    @(negedge clk);
    chk("R8 R9", "strobes drop", 64'({done_o, fault_o}), 64'h0);
  endtask

  initial begin
    vec_t hv;
    int req_cycles;
    logic addr_moved;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "ip reset", ip_o, 64'h0);
    chk("R10", "sp reset", sp_o, 64'h0);
    chk("R10", "ssp reset", ssp_o, 64'h0);
    chk("R10", "busy/req/strobes", 64'({busy_o, dmem_req_o, ss_req_o, done_o, fault_o}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1 back-pressure and R9 start ignored while busy
    d_lat = 3;
    hv = VECS[0];
    hv.sp = 64'h2200;
    launch(hv);
    req_cycles = 0; addr_moved = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (done_o || fault_o) break;
      if (dmem_req_o) begin
        req_cycles++;
        if (dmem_addr_o !== 64'h2200) addr_moved = 1'b1;
      end
      if (k == 1) begin start_i = 1'b1; sp_i = 64'h9990; end
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R1", "request held cycles", 64'(req_cycles), 64'(d_lat + 1));
    chk("R1", "address stable", 64'(addr_moved), 64'h0);
    chk("R1", "size code", 64'(dmem_size_o), 64'h1);
    chk("R9", "first op result", sp_o, 64'h2204);
    @(negedge clk);
    chk("R9", "done one cycle", 64'(done_o), 64'h0);
    repeat (5) @(negedge clk);
    chk("R9", "no second op", 64'({busy_o, dmem_req_o}), 64'h0);
    chk("R9", "sp untouched by ignored start", sp_o, 64'h2204);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule